// File: doc/BRIEF.md
# Multiplexed-Bus Converter Host Controller

This block is the host side of an 8-bit multiplexed parallel link to a 12-bit data converter. A single request carries the channel, the full-scale range, the polarity, the power mode and the acquisition style. The controller turns these into a control byte and writes it with a timed write strobe. It then waits for the converter's active-low completion interrupt. It fetches the result as two byte reads, the low byte first and then the high byte, with a byte-select line choosing between them. The 12-bit code comes out as a 16-bit word: zero-extended for unipolar conversions and sign-extended for bipolar ones.

When host-timed acquisition is requested, the controller writes twice. The first byte opens the acquisition window and the second closes it and starts the conversion. Both bytes carry the same channel, range and polarity. A parameterised number of system-clock cycles separates the two writes. Strobe lengths and bus-release gaps are counted in system-clock cycles. At elaboration the parameters are checked against the converter's minimum strobe and release times for the given clock period.

A new request is only taken while the controller is idle. A request that arrives during a transaction is ignored, and the controller reports completion with a one-cycle valid pulse.

Top module: `adcbus_master`

## Requirements
- R1: While reset is applied and after it is released with no request, chip select, write strobe and read strobe are high, the bus drive enable is low, busy and result-valid are low and the result word is zero.
- R2: The control byte places the channel in bits 2..0, the polarity in bit 3 (1 = bipolar), the range in bit 4, the acquisition style in bit 5 and the power mode in bits 7..6. An internally timed request issues exactly one write whose bit 5 is 0.
- R3: A host-timed request issues two writes. The first has bit 5 = 1 and the second has bit 5 = 0, and bits 4..0 are identical in both. The write strobe stays high for exactly GAP_CYC + ACQ_HOLD_CYC cycles between them.
- R4: Every write holds the strobe low for exactly WR_LOW_CYC cycles, with chip select low and a constant byte driven.
- R5: The bus drive enable is high only while the write strobe and chip select are both low.
- R6: The result is fetched by two reads, the first with byte select 0 and the second with byte select 1. Each read holds the strobe low for exactly RD_LOW_CYC cycles, and the strobe stays high for exactly GAP_CYC cycles between the reads. Read and write strobes are never low together.
- R7: The first read starts only after the interrupt has been seen low. The second read does not wait for the interrupt, because the first read has consumed it.
- R8: In unipolar mode the result is {4'b0, high byte bits 3..0, low byte}. High-byte bus bits 7..4 are ignored, whatever their value.
- R9: In bipolar mode the result bits 15..12 are copies of result bit 11 (two's complement sign extension).
- R10: Busy rises in the cycle after a request is accepted. Result-valid is a single-cycle pulse that follows both reads, and busy is low in the following cycle.
- R11: A request presented while busy is dropped. No further write happens, and the transaction in flight completes with its own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start a transaction (taken only when idle) |
| req_chan | input | 3 | Converter input channel |
| req_range | input | 1 | Full-scale range select |
| req_bipolar | input | 1 | 1 = bipolar (two's complement) conversion |
| req_pwr | input | 2 | Power mode field for the control byte |
| req_ext_acq | input | 1 | 1 = host-timed two-write acquisition |
| busy | output | 1 | Transaction in progress |
| res_valid | output | 1 | One-cycle pulse: res_data holds a new result |
| res_data | output | 16 | Extended 12-bit conversion result |
| bus_cs_n | output | 1 | Converter chip select, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_hben | output | 1 | Byte select: 1 = upper nibble byte |
| bus_oe | output | 1 | Drive enable for bus_dout onto the shared bus |
| bus_dout | output | 8 | Control byte to the bus |
| bus_din | input | 8 | Byte read from the bus |
| irq_n | input | 1 | Converter completion interrupt, active low |

## Verification
A wrong sequencer state shows up on the strobes within one write or read window. Examples are a strobe one cycle too long, a missing second write, or a high-byte read issued with the low select. The bench measures these pulse by pulse against the converter model. A wrong acquisition flag or a mismatched channel shows up on the written byte in the very write where it occurs. A wrong capture or extension path is only visible at result-valid, so each transaction is run with codes that have bit 11 both set and clear. Junk in the high-byte fill bits makes a capture that uses those bits give a wrong result word.

// File: rtl/adcbus_pkg.sv
package adcbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_WGAP,
    ST_HOLD,
    ST_WAIT,
    ST_READ,
    ST_RGAP,
    ST_DONE
  } adcbus_state_e;

  typedef struct packed {
    logic [1:0] pwr;
    logic       ext;
    logic       rng;
    logic       bip;
    logic [2:0] chan;
  } adcbus_cfg_t;

  // Control byte: [7:6] power, [5] acquisition, [4] range, [3] polarity, [2:0] channel
  function automatic logic [7:0] ctrl_byte(adcbus_cfg_t c, logic acq);
    return {c.pwr, acq, c.rng, c.bip, c.chan};
  endfunction

endpackage

// File: rtl/adcbus_cnt.sv
module adcbus_cnt #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/adcbus_result.sv
module adcbus_result #(
  parameter int BUS_W = 8,
  parameter int RES_W = 12,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_lo,
  input  logic             cap_hi,
  input  logic             bip,
  input  logic [BUS_W-1:0] din,
  output logic [OUT_W-1:0] result
);

  localparam int HI_W  = RES_W - BUS_W;
  localparam int EXT_W = OUT_W - RES_W;

  logic [BUS_W-1:0] lo_q;
  logic [OUT_W-1:0] res_q;
  logic [EXT_W-1:0] fill;

  // Extension comes from the captured code and the request polarity,
  // never from the upper bus bits of the high byte.
  assign fill = bip ? {EXT_W{din[HI_W-1]}} : {EXT_W{1'b0}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (cap_lo) begin
      lo_q <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (cap_hi) begin
      res_q <= {fill, din[HI_W-1:0], lo_q};
    end
  end

  assign result = res_q;

endmodule

// File: rtl/adcbus_master.sv
module adcbus_master
  import adcbus_pkg::*;
#(
  parameter int CLK_NS       = 10,
  parameter int WR_LOW_CYC   = 8,
  parameter int RD_LOW_CYC   = 12,
  parameter int GAP_CYC      = 7,
  parameter int ACQ_HOLD_CYC = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [2:0]  req_chan,
  input  logic        req_range,
  input  logic        req_bipolar,
  input  logic [1:0]  req_pwr,
  input  logic        req_ext_acq,
  output logic        busy,
  output logic        res_valid,
  output logic [15:0] res_data,
  output logic        bus_cs_n,
  output logic        bus_wr_n,
  output logic        bus_rd_n,
  output logic        bus_hben,
  output logic        bus_oe,
  output logic [7:0]  bus_dout,
  input  logic [7:0]  bus_din,
  input  logic        irq_n
);

  localparam int MAX_AB = (WR_LOW_CYC > RD_LOW_CYC) ? WR_LOW_CYC : RD_LOW_CYC;
  localparam int MAX_CD = (GAP_CYC > ACQ_HOLD_CYC) ? GAP_CYC : ACQ_HOLD_CYC;
  localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW     = $clog2(MAXC + 1);

  localparam logic [CW-1:0] WR_LEN   = CW'(WR_LOW_CYC - 1);
  localparam logic [CW-1:0] RD_LEN   = CW'(RD_LOW_CYC - 1);
  localparam logic [CW-1:0] GAP_LEN  = CW'(GAP_CYC - 1);
  localparam logic [CW-1:0] HOLD_LEN = CW'(ACQ_HOLD_CYC - 1);

  // Converter minimums: 80 ns write, 120 ns read access, 70 ns bus release
  if ((WR_LOW_CYC * CLK_NS < 80) || (RD_LOW_CYC * CLK_NS < 120) ||
      (GAP_CYC * CLK_NS < 70) || (ACQ_HOLD_CYC < 1)) begin : g_bad_timing
    $error("adcbus_master: strobe cycle counts too short for CLK_NS");
  end

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  adcbus_state_e state_q, state_d;
  adcbus_cfg_t   cfg_q, cfg_d;
  logic          second_q, second_d;
  logic          hi_q, hi_d;
  logic          tmr_load, tmr_done;
  logic [CW-1:0] tmr_val;
  logic          cap_lo, cap_hi;

  adcbus_cnt #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_i),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  adcbus_result #(.BUS_W(8), .RES_W(12), .OUT_W(16)) u_res (
    .clk    (clk),
    .rst_n  (rst_i),
    .cap_lo (cap_lo),
    .cap_hi (cap_hi),
    .bip    (cfg_q.bip),
    .din    (bus_din),
    .result (res_data)
  );

  always_comb begin
    state_d  = state_q;
    cfg_d    = cfg_q;
    second_d = second_q;
    hi_d     = hi_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cap_lo   = 1'b0;
    cap_hi   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req) begin
        cfg_d    = '{pwr: req_pwr, ext: req_ext_acq, rng: req_range,
                     bip: req_bipolar, chan: req_chan};
        second_d = 1'b0;
        hi_d     = 1'b0;
        tmr_load = 1'b1;
        tmr_val  = WR_LEN;
        state_d  = ST_WRITE;
      end
      ST_WRITE: if (tmr_done) begin
        tmr_load = 1'b1;
        tmr_val  = GAP_LEN;
        state_d  = ST_WGAP;
      end
      ST_WGAP: if (tmr_done) begin
        if (cfg_q.ext && !second_q) begin
          tmr_load = 1'b1;
          tmr_val  = HOLD_LEN;
          state_d  = ST_HOLD;
        end else begin
          state_d  = ST_WAIT;
        end
      end
      ST_HOLD: if (tmr_done) begin
        second_d = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = WR_LEN;
        state_d  = ST_WRITE;
      end
      ST_WAIT: if (!irq_n) begin
        hi_d     = 1'b0;
        tmr_load = 1'b1;
        tmr_val  = RD_LEN;
        state_d  = ST_READ;
      end
      ST_READ: if (tmr_done) begin
        cap_lo   = !hi_q;
        cap_hi   = hi_q;
        tmr_load = 1'b1;
        tmr_val  = GAP_LEN;
        state_d  = ST_RGAP;
      end
      ST_RGAP: if (tmr_done) begin
        if (!hi_q) begin
          hi_d     = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = RD_LEN;
          state_d  = ST_READ;
        end else begin
          state_d  = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q  <= ST_IDLE;
      cfg_q    <= '0;
      second_q <= 1'b0;
      hi_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      second_q <= second_d;
      hi_q     <= hi_d;
      if (state_q == ST_IDLE) cfg_q <= cfg_d;
    end
  end

  // Bus pins are registered from the next state so they never glitch
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      bus_cs_n <= 1'b1;
      bus_wr_n <= 1'b1;
      bus_rd_n <= 1'b1;
      bus_hben <= 1'b0;
      bus_oe   <= 1'b0;
      bus_dout <= '0;
    end else begin
      bus_cs_n <= !((state_d == ST_WRITE) || (state_d == ST_READ));
      bus_wr_n <= (state_d != ST_WRITE);
      bus_rd_n <= (state_d != ST_READ);
      bus_hben <= hi_d;
      bus_oe   <= (state_d == ST_WRITE);
      if (state_d == ST_WRITE) bus_dout <= ctrl_byte(cfg_d, cfg_d.ext & ~second_d);
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign res_valid = (state_q == ST_DONE);

endmodule

// File: rtl/adcbus_master_chk.sv
module adcbus_master_chk #(
  parameter int WR_LOW_CYC = 8,
  parameter int RD_LOW_CYC = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_n,
  input logic       busy,
  input logic       res_valid,
  input logic       bus_cs_n,
  input logic       bus_wr_n,
  input logic       bus_rd_n,
  input logic       bus_hben,
  input logic       bus_oe,
  input logic [7:0] bus_dout
);

  int         wcnt, rcnt;
  logic       wr_prev, rd_prev, irq_seen, acq_open;
  logic [7:0] first_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt       <= 0;
      rcnt       <= 0;
      wr_prev    <= 1'b1;
      rd_prev    <= 1'b1;
      irq_seen   <= 1'b0;
      acq_open   <= 1'b0;
      first_byte <= '0;
    end else begin
      wcnt    <= bus_wr_n ? 0 : wcnt + 1;
      rcnt    <= bus_rd_n ? 0 : rcnt + 1;
      wr_prev <= bus_wr_n;
      rd_prev <= bus_rd_n;
      if (!bus_wr_n && wr_prev) irq_seen <= 1'b0;
      else if (!irq_n)          irq_seen <= 1'b1;
      if (!bus_wr_n && wr_prev) begin
        acq_open   <= bus_dout[5];
        first_byte <= bus_dout;
      end
    end
  end

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_wr_n && !bus_rd_n));

  assert_drive_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (!bus_wr_n && !bus_cs_n));

  assert_wr_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_n && !wr_prev) |-> (wcnt == WR_LOW_CYC));

  assert_wr_data_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_n && !wr_prev) |-> $stable(bus_dout));

  assert_rd_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_n && !rd_prev) |-> (rcnt == RD_LOW_CYC));

  assert_hben_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n && !rd_prev) |-> $stable(bus_hben));

  assert_same_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_n && wr_prev && acq_open) |-> (bus_dout[4:0] == first_byte[4:0]));

  assert_read_after_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n && rd_prev && !bus_hben) |-> irq_seen);

  assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_valid_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> busy);

endmodule

bind adcbus_master adcbus_master_chk #(
  .WR_LOW_CYC (WR_LOW_CYC),
  .RD_LOW_CYC (RD_LOW_CYC)
) u_adcbus_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_n     (irq_n),
  .busy      (busy),
  .res_valid (res_valid),
  .bus_cs_n  (bus_cs_n),
  .bus_wr_n  (bus_wr_n),
  .bus_rd_n  (bus_rd_n),
  .bus_hben  (bus_hben),
  .bus_oe    (bus_oe),
  .bus_dout  (bus_dout)
);

// File: tb/adcbus_master_bench.sv
module adcbus_master_bench;

  localparam int WR   = 8;
  localparam int RD   = 12;
  localparam int GAP  = 7;
  localparam int HOLD = 25;
  localparam int CONV = 30;

  logic        clk, rst_n;
  logic        req, req_range, req_bipolar, req_ext_acq;
  logic [2:0]  req_chan;
  logic [1:0]  req_pwr;
  logic        busy, res_valid;
  logic [15:0] res_data;
  logic        bus_cs_n, bus_wr_n, bus_rd_n, bus_hben, bus_oe;
  logic [7:0]  bus_dout, bus_din;
  logic        irq_n;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  adcbus_master #(
    .CLK_NS(10), .WR_LOW_CYC(WR), .RD_LOW_CYC(RD), .GAP_CYC(GAP), .ACQ_HOLD_CYC(HOLD)
  ) u_adcbus_master (
    .clk(clk), .rst_n(rst_n), .req(req), .req_chan(req_chan), .req_range(req_range),
    .req_bipolar(req_bipolar), .req_pwr(req_pwr), .req_ext_acq(req_ext_acq),
    .busy(busy), .res_valid(res_valid), .res_data(res_data),
    .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .bus_hben(bus_hben),
    .bus_oe(bus_oe), .bus_dout(bus_dout), .bus_din(bus_din), .irq_n(irq_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- converter model ----------------
  logic [11:0] conv_val;
  logic        junk_fill;
  logic        clr_tog, clr_seen;
  logic        prev_wr_n, prev_rd_n, conv_on, irq_taken, bip_mode;
  logic [7:0]  wlast;
  logic [7:0]  wbyte [4];
  int          wwid [4];
  int          rwid [4];
  logic        rhb [4];
  int wr_w, rd_w, nwr, nrd, wgap_cnt, wgap, rgap_cnt, rgap, rd_early, oe_viol, conv_cnt;

  assign bus_din = (!bus_rd_n && !bus_cs_n)
                 ? (bus_hben ? {(junk_fill ? 4'hF : (bip_mode ? {4{conv_val[11]}} : 4'h0)),
                                conv_val[11:8]}
                             : conv_val[7:0])
                 : 8'hA5;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_wr_n = 1'b1; prev_rd_n = 1'b1; irq_n = 1'b1; conv_on = 1'b0;
      irq_taken = 1'b0; bip_mode = 1'b0; clr_seen = clr_tog;
      nwr = 0; nrd = 0; rd_early = 0; oe_viol = 0; wgap = -1; rgap = -1;
      wgap_cnt = 0; rgap_cnt = 0; wr_w = 0; rd_w = 0; conv_cnt = 0; wlast = 8'h00;
    end else begin
      if (clr_seen != clr_tog) begin
        clr_seen = clr_tog;
        nwr = 0; nrd = 0; rd_early = 0; oe_viol = 0; wgap = -1; rgap = -1;
      end
      if (bus_oe && (bus_wr_n || bus_cs_n)) oe_viol++;
      if (!bus_wr_n) begin
        if (prev_wr_n) begin
          wr_w = 0;
          if (nwr == 1) wgap = wgap_cnt;
        end
        wr_w++;
        wlast = bus_dout;
      end else if (!prev_wr_n) begin
        if (nwr < 4) begin wbyte[nwr] = wlast; wwid[nwr] = wr_w; end
        nwr++;
        wgap_cnt = 1;
        irq_n = 1'b1;
        irq_taken = 1'b0;
        if (!wlast[5]) begin conv_on = 1'b1; conv_cnt = CONV; bip_mode = wlast[3]; end
        else conv_on = 1'b0;
      end else begin
        wgap_cnt++;
      end
      if (conv_on) begin
        if (conv_cnt == 0) begin irq_n = 1'b0; conv_on = 1'b0; end
        else conv_cnt--;
      end
      if (!bus_rd_n && !bus_cs_n) begin
        if (prev_rd_n) begin
          rd_w = 0;
          if (nrd < 4) rhb[nrd] = bus_hben;
          if (nrd == 1) rgap = rgap_cnt;
          if (!irq_taken) begin
            if (irq_n) rd_early++;
            else irq_taken = 1'b1;
          end
          irq_n = 1'b1;
        end
        rd_w++;
      end else if (!prev_rd_n) begin
        if (nrd < 4) rwid[nrd] = rd_w;
        nrd++;
        rgap_cnt = 1;
      end else begin
        rgap_cnt++;
      end
      prev_wr_n = bus_wr_n;
      prev_rd_n = bus_rd_n;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    clr_tog = !clr_tog;
    @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] ch, input logic rng, input logic bip,
                       input logic [1:0] pwr, input logic ext);
    req_chan = ch; req_range = rng; req_bipolar = bip; req_pwr = pwr; req_ext_acq = ext;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_result(output logic [15:0] r, output bit got);
    got = 0;
    r = '0;
    for (int i = 0; i < 3000 && !got; i++) begin
      @(negedge clk);
      if (res_valid) begin r = res_data; got = 1; end
    end
    chk("R10 result-valid seen", 32'(got), 32'd1);
    @(negedge clk);
    chk("R10 result-valid one cycle", 32'(res_valid), 32'd0);
    chk("R10 busy low after valid", 32'(busy), 32'd0);
  endtask

  task automatic run_txn(input logic [2:0] ch, input logic rng, input logic bip,
                         input logic [1:0] pwr, input logic ext,
                         input logic [11:0] val, input logic junk);
    logic [7:0]  b_conv, b_acq;
    logic [15:0] exp_res, got_res;
    bit          got;
    conv_val  = val;
    junk_fill = junk;
    clear_log();
    b_conv  = {pwr, 1'b0, rng, bip, ch};
    b_acq   = {pwr, 1'b1, rng, bip, ch};
    exp_res = bip ? {{4{val[11]}}, val} : {4'h0, val};
    issue(ch, rng, bip, pwr, ext);
    chk("R10 busy after accept", 32'(busy), 32'd1);
    wait_result(got_res, got);
    if (ext) begin
      chk("R3 write count", nwr, 2);
      chk("R3 first byte", 32'(wbyte[0]), 32'(b_acq));
      chk("R3 second byte", 32'(wbyte[1]), 32'(b_conv));
      chk("R3 hold between writes", wgap, GAP + HOLD);
      chk("R4 first write width", wwid[0], WR);
      chk("R4 second write width", wwid[1], WR);
    end else begin
      chk("R2 write count", nwr, 1);
      chk("R2 control byte", 32'(wbyte[0]), 32'(b_conv));
      chk("R4 write width", wwid[0], WR);
    end
    chk("R5 drive outside write", oe_viol, 0);
    chk("R6 read count", nrd, 2);
    chk("R6 first read low select", 32'(rhb[0]), 32'd0);
    chk("R6 second read high select", 32'(rhb[1]), 32'd1);
    chk("R6 first read width", rwid[0], RD);
    chk("R6 second read width", rwid[1], RD);
    chk("R6 gap between reads", rgap, GAP);
    chk("R7 read before interrupt", rd_early, 0);
    if (bip) chk("R9 bipolar result", 32'(got_res), 32'(exp_res));
    else     chk("R8 unipolar result", 32'(got_res), 32'(exp_res));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 cs in reset", 32'(bus_cs_n), 32'd1);
    chk("R1 wr in reset", 32'(bus_wr_n), 32'd1);
    chk("R1 rd in reset", 32'(bus_rd_n), 32'd1);
    chk("R1 oe in reset", 32'(bus_oe), 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 busy after reset", 32'(busy), 32'd0);
    chk("R1 valid after reset", 32'(res_valid), 32'd0);
    chk("R1 result after reset", 32'(res_data), 32'd0);
    chk("R1 strobes idle", 32'({bus_cs_n, bus_wr_n, bus_rd_n}), 32'd7);
  endtask

  task automatic t_internal_unipolar();
    run_txn(3'd5, 1'b1, 1'b0, 2'b00, 1'b0, 12'hABC, 1'b0);   // R2 R8
  endtask

  task automatic t_internal_bipolar_neg();
    run_txn(3'd2, 1'b0, 1'b1, 2'b01, 1'b0, 12'h9F3, 1'b0);   // R9
  endtask

  task automatic t_internal_bipolar_pos();
    run_txn(3'd7, 1'b1, 1'b1, 2'b11, 1'b0, 12'h7FF, 1'b0);   // R9
  endtask

  task automatic t_unipolar_junk_fill();
    run_txn(3'd0, 1'b0, 1'b0, 2'b00, 1'b0, 12'h800, 1'b1);   // R8 upper bits ignored
  endtask

  task automatic t_external();
    run_txn(3'd3, 1'b1, 1'b1, 2'b10, 1'b1, 12'h001, 1'b0);   // R3
    run_txn(3'd6, 1'b0, 1'b0, 2'b00, 1'b1, 12'hFFF, 1'b0);   // R3 R8
  endtask

  task automatic t_holdoff();
    logic [15:0] got_res;
    bit          got;
    conv_val  = 12'h123;
    junk_fill = 1'b0;
    clear_log();
    issue(3'd1, 1'b0, 1'b0, 2'b00, 1'b0);
    repeat (10) @(negedge clk);
    issue(3'd6, 1'b1, 1'b1, 2'b11, 1'b1);                    // R11 arrives while busy
    chk("R11 still busy", 32'(busy), 32'd1);
    wait_result(got_res, got);
    chk("R11 first result intact", 32'(got_res), 32'h0123);
    repeat (80) @(negedge clk);
    chk("R11 no extra write", nwr, 1);
    chk("R11 channel of in-flight request", 32'(wbyte[0][2:0]), 32'd1);
    chk("R11 idle after drop", 32'(busy), 32'd0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog R10 actual=no completion expected=completion");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; req_chan = '0; req_range = 1'b0; req_bipolar = 1'b0;
    req_pwr = '0; req_ext_acq = 1'b0; conv_val = '0; junk_fill = 1'b0; clr_tog = 1'b0;
    t_reset();
    t_internal_unipolar();
    t_internal_bipolar_neg();
    t_internal_bipolar_pos();
    t_unipolar_junk_fill();
    t_external();
    t_holdoff();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule